// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block is the write-only serial front end of a display controller. A host drives four wires: a serial clock, a serial data line, a data/command select line and an active-low chip select. While chip select is low, the block collects one bit on each rising serial-clock edge, most significant bit first, until it has a full byte. On the edge that completes the byte, it reads the select line and hands the byte on. A high select line sends the byte to the display memory write port. A low select line sends it to the command register port.

All four wires are brought into the system clock domain through synchronizer flops. The receiver then works entirely on the system clock. Each completed byte produces one single-cycle strobe on exactly one of the two write outputs, and the byte itself is presented alongside. Raising chip select clears the bit counter, so any partial byte is dropped and the next byte starts cleanly. A burst of display data is normally closed with a no-operation command byte (0xE3) before chip select goes high. The receiver forwards that byte like any other command.

Top module: `spi_byte_rx`

## Requirements
- R1: After reset, `ram_wr` and `cmd_wr` are low and `byte_out` is 0x00.
- R2: The byte is assembled most significant bit first: the bit taken on the first rising `ser_clk` edge after chip select falls lands in `byte_out[7]`, and the bit on the eighth edge lands in `byte_out[0]`.
- R3: If `dc_sel` is 1 on the eighth edge, the byte goes out with `ram_wr`. If `dc_sel` is 0, it goes out with `cmd_wr`. The two strobes are never high together.
- R4: Each completed byte produces exactly one strobe, and that strobe is high for exactly one system clock cycle.
- R5: `dc_sel` is looked at only on the eighth edge. Its level during the first seven edges has no effect on which strobe fires.
- R6: A rise of `cs_n` clears the bit count, so a partial byte is discarded and the next byte is assembled from scratch.
- R7: `ser_clk` edges that arrive while `cs_n` is high collect no bits and produce no strobe. If chip select is released at the same time as the eighth edge, the byte is discarded.
- R8: The no-operation byte 0xE3, sent with `dc_sel` low, comes out as an ordinary `cmd_wr` with `byte_out` = 0xE3.
- R9: `byte_out` changes only in a cycle where a strobe is high, and otherwise holds the last byte delivered.
- R10: Bytes sent back to back under one chip-select low period are each delivered in order, with no gap needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host; data taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| dc_sel | input | 1 | 1 = display data, 0 = command; read on the eighth edge |
| cs_n | input | 1 | Active-low chip select |
| byte_out | output | WORD_BITS | Last completed byte |
| ram_wr | output | 1 | One-cycle display memory write strobe |
| cmd_wr | output | 1 | One-cycle command register write strobe |

## Verification
Two events can land in the same system cycle: the release of chip select, which clears the bit counter, and the eighth serial-clock edge, which would complete and dispatch a byte. The bench provokes this by raising `cs_n` and `ser_clk` in the same instant, so both pass through identical synchronizer depths and reach the receiver in the same cycle. The expected outcome is that the release wins. No strobe may appear, and the scoreboard flags any unexpected write. A following complete byte must then arrive intact, which shows that the counter really was cleared.

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 dc_sel,
  input  logic                 cs_n,
  output logic [WORD_BITS-1:0] byte_out,
  output logic                 ram_wr,
  output logic                 cmd_wr
);
  localparam int CW = $clog2(WORD_BITS);

  logic [SYNC_STAGES-1:0] sck_q, dat_q, dc_q, cs_q;
  logic                   sck_prev;
  logic [CW-1:0]          cnt;
  logic [WORD_BITS-1:0]   shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      dat_q    <= '0;
      dc_q     <= '0;
      cs_q     <= '1;
      sck_prev <= 1'b0;
    end else begin
      sck_q    <= {sck_q[SYNC_STAGES-2:0], ser_clk};
      dat_q    <= {dat_q[SYNC_STAGES-2:0], ser_dat};
      dc_q     <= {dc_q[SYNC_STAGES-2:0], dc_sel};
      cs_q     <= {cs_q[SYNC_STAGES-2:0], cs_n};
      sck_prev <= sck_q[SYNC_STAGES-1];
    end
  end

  wire sck_s = sck_q[SYNC_STAGES-1];
  wire dat_s = dat_q[SYNC_STAGES-1];
  wire dc_s  = dc_q[SYNC_STAGES-1];
  wire cs_s  = cs_q[SYNC_STAGES-1];

  wire                 rise      = sck_s & ~sck_prev & ~cs_s;
  wire                 last_bit  = (cnt == CW'(WORD_BITS-1));
  wire [WORD_BITS-1:0] assembled = {shreg[WORD_BITS-2:0], dat_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      byte_out <= '0;
      ram_wr   <= 1'b0;
      cmd_wr   <= 1'b0;
    end else begin
      ram_wr <= 1'b0;
      cmd_wr <= 1'b0;
      if (cs_s) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= assembled;
        if (last_bit) begin
          cnt      <= '0;
          byte_out <= assembled;
          ram_wr   <= dc_s;
          cmd_wr   <= ~dc_s;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_wr && cmd_wr));

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr || cmd_wr) |=> !(ram_wr || cmd_wr));

  p_cs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0));

  p_cs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !(ram_wr || cmd_wr));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_wr || cmd_wr) |-> (byte_out == $past(byte_out)));
endmodule

// File: tb/spi_byte_rx_tb_top.sv
module spi_byte_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, dc_sel = 1'b0, cs_n = 1'b1;
  logic [7:0] byte_out;
  logic ram_wr, cmd_wr;

  int checks = 0, fails = 0, strobes = 0;
  logic [8:0] expq[$];
  logic [7:0] last_byte = 8'h00;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_byte_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .dc_sel(dc_sel), .cs_n(cs_n), .byte_out(byte_out),
    .ram_wr(ram_wr), .cmd_wr(cmd_wr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit; dc driven with the bit
  task automatic send_bit(input bit b, input bit dc);
    ser_dat = b; dc_sel = dc;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  // R5: dc_bad is driven on the first seven bits, dc on the eighth
  task automatic send_byte(input logic [7:0] b, input bit dc, input bit dc_bad, input bit expect_it);
    if (expect_it) expq.push_back({dc, b});
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == 0) ? dc : dc_bad);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (ram_wr || cmd_wr)) begin
      strobes++;
      chk(!(ram_wr && cmd_wr), "R3 both strobes", {ram_wr, cmd_wr}, 0);
      if (expq.size() == 0) begin
        chk(1'b0, "R7 unexpected strobe", byte_out, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk(byte_out == e[7:0], "R2 byte value", byte_out, e[7:0]);
        chk(ram_wr == e[8], "R3 strobe select", {ram_wr, cmd_wr}, e[8] ? 2 : 1);
        last_byte = byte_out;
      end
    end
  end

  // R4: a strobe never lasts more than one cycle
  logic prev_stb = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_stb && (ram_wr || cmd_wr))
      chk(1'b0, "R4 strobe width", 2, 1);
    prev_stb = ram_wr || cmd_wr;
  end

  // R9: byte_out holds between strobes
  logic [7:0] held = 8'h00;
  always @(negedge clk) begin
    if (rst_n && !(ram_wr || cmd_wr) && byte_out != held)
      chk(1'b0, "R9 byte_out changed without strobe", byte_out, held);
    held = byte_out;
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s0;
    wait_clk(3);
    chk(ram_wr == 0 && cmd_wr == 0, "R1 strobes at reset", {ram_wr, cmd_wr}, 0);
    chk(byte_out == 8'h00, "R1 byte at reset", byte_out, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R2/R3/R10: mixed back-to-back bytes in one select window
    cs_n = 1'b0; wait_clk(4);
    send_byte(8'hA5, 1'b0, 1'b0, 1'b1);
    send_byte(8'h81, 1'b1, 1'b1, 1'b1);
    send_byte(8'h3C, 1'b1, 1'b1, 1'b1);
    send_byte(8'hFF, 1'b1, 1'b1, 1'b1);
    send_byte(8'h00, 1'b1, 1'b1, 1'b1);
    // R8: trailing no-op command
    send_byte(8'hE3, 1'b0, 1'b0, 1'b1);
    wait_clk(8);
    chk(last_byte == 8'hE3, "R8 no-op as command", last_byte, 8'hE3);
    cs_n = 1'b1; wait_clk(8);
    chk(expq.size() == 0, "R10 all bytes delivered", expq.size(), 0);

    // R5: dc toggled wrong during first seven bits
    cs_n = 1'b0; wait_clk(4);
    send_byte(8'h5A, 1'b1, 1'b0, 1'b1);
    send_byte(8'h96, 1'b0, 1'b1, 1'b1);
    wait_clk(8);
    chk(expq.size() == 0, "R5 dc only on eighth edge", expq.size(), 0);

    // R6: partial byte then release
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
    wait_clk(2);
    cs_n = 1'b1; wait_clk(8);
    cs_n = 1'b0; wait_clk(4);
    send_byte(8'h12, 1'b0, 1'b0, 1'b1);
    wait_clk(8);
    chk(expq.size() == 0 && last_byte == 8'h12, "R6 partial discarded", last_byte, 8'h12);

    // R7: edges while deselected
    cs_n = 1'b1; wait_clk(4);
    s0 = strobes;
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1);
    wait_clk(8);
    chk(strobes == s0, "R7 edges ignored when deselected", strobes - s0, 0);

    // R7: release coincides with eighth edge
    cs_n = 1'b0; wait_clk(4);
    for (int i = 7; i >= 1; i--) send_bit(1'b0, 1'b1);
    ser_dat = 1'b1; wait_clk(4);
    ser_clk = 1'b1; cs_n = 1'b1;
    wait_clk(4); ser_clk = 1'b0;
    wait_clk(8);
    chk(strobes == s0, "R7 release wins over eighth edge", strobes - s0, 0);
    cs_n = 1'b0; wait_clk(4);
    send_byte(8'hC7, 1'b1, 1'b1, 1'b1);
    wait_clk(8);
    chk(strobes == s0 + 1 && last_byte == 8'hC7, "R6 fresh byte after coincident release", last_byte, 8'hC7);
    chk(byte_out == 8'hC7, "R9 byte held", byte_out, 8'hC7);
    cs_n = 1'b1; wait_clk(8);
    chk(expq.size() == 0, "R4 one strobe per byte", expq.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule